// File: doc/BRIEF.md
# ISA Expansion Bus Command Sequencer

This block runs single cycles on a 16-bit ISA-style expansion bus for an on-chip initiator: the host, a DMA channel or the refresh timer. A request carries a word address, byte enables, a direction, and a flag for memory, I/O or refresh. The sequencer pulses the address latch enable for one clock. It then asserts the right command strobe and qualifies the system-memory strobes for the lowest megabyte. It drives the byte-high enable and the DMA address-enable.

The addressed device controls the shape of each memory cycle. Its 16-bit select, sampled during the latch-enable clock, picks one 16-bit transfer. Without that select the block runs 8-bit transfers. A request for both bytes then becomes two narrow transfers, and the upper byte travels on the low data lanes. The zero-wait input cuts a command to its minimum length. The channel-ready input holds a command for as long as it is low.

When the last command ends, the block pulses a completion flag and presents the read data, assembled into its natural byte positions.

Top module: `isa_cmd_gen`

## Requirements
- R1: After reset, `ale` is 0, all command and qualifier strobes (`memr_n`, `memw_n`, `ior_n`, `iow_n`, `smemr_n`, `smemw_n`, `bhe_n`) are 1, `aen` and `done` are 0, and `req_ready` is 1.
- R2: A request accepted on a clock edge (with `req_valid` and `req_ready` both 1) gives `ale` = 1 for exactly the next clock, with every command strobe inactive. The command strobe goes active in the clock after that. Each transfer of a cycle starts with its own such `ale` clock.
- R3: Exactly one command strobe is active during a command:
  - `memr_n` for a memory read or a refresh (`req_refresh` = 1);
  - `memw_n` for a memory write;
  - `ior_n` for an I/O read (`req_io` = 1, `req_write` = 0);
  - `iow_n` for an I/O write.
- R4: `smemr_n` follows `memr_n` only when address bits [23:20] are all zero or the cycle is a refresh. `smemw_n` follows `memw_n` only when address bits [23:20] are all zero. Otherwise both stay 1.
- R5: A memory cycle that sees `mcs16_n` = 0 during its `ale` clock is one 16-bit transfer. It uses data lanes [15:0], `sa[0]` = 1 only for `req_be` = 2'b10, and `bhe_n` = 0 whenever `req_be[1]` = 1.
- R6: `mcs16_n` is ignored for I/O and refresh cycles. I/O cycles always use 8-bit transfers. A refresh is a single transfer with `sa[0]` = 0, `bhe_n` = 1, and 16-bit timing.
- R7: An 8-bit cycle with `req_be` = 2'b11 runs as two transfers, low byte first (`sa[0]` = 0, then `sa[0]` = 1). In both transfers `bhe_n` = 1 and data moves on lanes [7:0]: the high write byte is driven on `sd_out[7:0]`, and the second read byte lands in `rdata[15:8]`. A single narrow byte also uses lanes [7:0], with `sa[0]` = 1 for `req_be` = 2'b10.
- R8: With `iochrdy` = 1 and `zws_n` = 1, a command lasts 4 clocks for 16-bit transfers and refresh, and 6 clocks for 8-bit transfers.
- R9: While `zws_n` = 0 the command ends after 2 clocks.
- R10: While `iochrdy` = 0 the active command does not end. It ends at the first edge where `iochrdy` = 1 and the width of R8 or R9 has been reached.
- R11: `aen` is 1 for every busy clock (`ale` clock through the last command clock) of a DMA request (`req_dma` = 1, not refresh), and 0 otherwise.
- R12: `done` is 1 for exactly the clock after the last command clock, and `req_ready` returns to 1 in that same clock. `rdata` then holds the read bytes of the enabled lanes and zero elsewhere; it is all zero for writes and refresh. Requests offered while busy are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Cycle request, taken when `req_ready` is 1 |
| req_ready | output | 1 | Sequencer idle |
| req_addr | input | 24 | Byte address; bit 0 is replaced by the lane logic |
| req_write | input | 1 | 1 = write, 0 = read |
| req_io | input | 1 | 1 = I/O space, 0 = memory |
| req_refresh | input | 1 | Refresh cycle; overrides `req_io` and `req_write` |
| req_dma | input | 1 | Request comes from a DMA channel |
| req_be | input | 2 | Byte enables, bit 1 = upper byte |
| req_wdata | input | 16 | Write data in natural byte positions |
| done | output | 1 | One-clock completion pulse |
| rdata | output | 16 | Read data, valid with `done` |
| ale | output | 1 | Address latch enable, active high |
| sa | output | 24 | Bus address with lane-adjusted bit 0 |
| bhe_n | output | 1 | Byte-high enable, active low |
| memr_n | output | 1 | Memory read command |
| memw_n | output | 1 | Memory write command |
| ior_n | output | 1 | I/O read command |
| iow_n | output | 1 | I/O write command |
| smemr_n | output | 1 | Low-megabyte memory read |
| smemw_n | output | 1 | Low-megabyte memory write |
| aen | output | 1 | DMA address enable |
| sd_out | output | 16 | Write data lanes |
| sd_in | input | 16 | Read data lanes |
| mcs16_n | input | 1 | Device 16-bit memory select, sampled in the `ale` clock |
| zws_n | input | 1 | Zero-wait request |
| iochrdy | input | 1 | Channel ready; low stretches the command |

## Verification
The properties assume that the responding device gives `mcs16_n` a settled value in the latch-enable clock. They also assume that `iochrdy` returns high within a bounded time, so that a stretched command always finishes. The bench drives every bus input on the falling edge. It holds `mcs16_n` steady for the whole cycle. It releases `iochrdy` after a chosen number of command clocks, so every wait window is finite and known ahead of time. Refresh and I/O cycles are run with both values of `mcs16_n`; this shows that the select is ignored there without breaking any property.

// File: rtl/isa_cmd_pkg.sv
// Shared types for the expansion-bus command sequencer.
// Assumes: a cycle is exactly one of memory, I/O or refresh.
package isa_cmd_pkg;

    typedef enum logic [1:0] {
        KIND_MEM = 2'd0,
        KIND_IO  = 2'd1,
        KIND_REF = 2'd2
    } cyc_kind_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_ALE  = 2'd1,
        ST_CMD  = 2'd2
    } seq_state_e;

endpackage

// File: rtl/isa_cmd_width.sv
// Command width timer.
// Counts the clocks of the active command and raises `finish` on the clock
// whose edge ends it. The command ends on the long or short width, or after
// the minimum width under zero-wait, and only while the channel is ready.
// Assumes: `active` is high for the whole command, low between transfers.
module isa_cmd_width #(
    parameter int W16  = 4,
    parameter int W8   = 6,
    parameter int WMIN = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic active,
    input  logic narrow,
    input  logic zws_n,
    input  logic iochrdy,
    output logic finish
);
    localparam int LONGEST = (W16 > W8) ? W16 : W8;
    localparam int CNT_W   = $clog2(LONGEST + 1) + 1;

    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] limit;
    logic             width_met;

    // Select the nominal width of the current transfer.
    always_comb begin
        limit     = narrow ? CNT_W'(W8) : CNT_W'(W16);
        width_met = (cnt >= limit) || (!zws_n && (cnt >= CNT_W'(WMIN)));
        finish    = active && iochrdy && width_met;
    end

    // Count command clocks, starting at one and saturating at the longest width.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= CNT_W'(1);
        end else if (!active || finish) begin
            cnt <= CNT_W'(1);
        end else if (cnt < CNT_W'(LONGEST)) begin
            cnt <= cnt + CNT_W'(1);
        end
    end

endmodule

// File: rtl/isa_cmd_strobe.sv
// Command and qualifier strobe decode.
// Turns the sequencer phase and the latched cycle attributes into the
// active-low bus strobes and the DMA address enable.
// Assumes: inputs come from registers, so the strobes change only on edges.
module isa_cmd_strobe
    import isa_cmd_pkg::*;
(
    input  cyc_kind_e kind,
    input  logic      cmd_on,
    input  logic      busy,
    input  logic      write,
    input  logic      dma,
    input  logic      below_low,
    output logic      memr_n,
    output logic      memw_n,
    output logic      ior_n,
    output logic      iow_n,
    output logic      smemr_n,
    output logic      smemw_n,
    output logic      aen
);
    logic memr, memw, ior, iow;

    // Pick the one command that matches the cycle type and direction.
    always_comb begin
        memr = cmd_on && ((kind == KIND_REF) || ((kind == KIND_MEM) && !write));
        memw = cmd_on && (kind == KIND_MEM) && write;
        ior  = cmd_on && (kind == KIND_IO) && !write;
        iow  = cmd_on && (kind == KIND_IO) && write;
    end

    // Drive the low-active strobes and the low-megabyte qualifiers.
    always_comb begin
        memr_n  = !memr;
        memw_n  = !memw;
        ior_n   = !ior;
        iow_n   = !iow;
        smemr_n = !(memr && (below_low || (kind == KIND_REF)));
        smemw_n = !(memw && below_low);
        aen     = busy && dma;
    end

endmodule

// File: rtl/isa_cmd_seq.sv
// Cycle sequencer.
// Latches one request, steps through latch-enable and command phases per
// transfer, and splits a two-byte cycle on an 8-bit device into low byte
// then high byte. It steers bytes across the lanes and assembles read data.
// Assumes: `finish` comes from the width timer and is only high in ST_CMD.
module isa_cmd_seq
    import isa_cmd_pkg::*;
#(
    parameter int ADDR_W   = 24,
    parameter int LOW_BITS = 20,
    parameter int LANE_W   = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  req_valid,
    input  logic [ADDR_W-1:0]     req_addr,
    input  logic                  req_write,
    input  logic                  req_io,
    input  logic                  req_refresh,
    input  logic                  req_dma,
    input  logic [1:0]            req_be,
    input  logic [2*LANE_W-1:0]   req_wdata,
    input  logic                  mcs16_n,
    input  logic [2*LANE_W-1:0]   sd_in,
    input  logic                  finish,
    output logic                  req_ready,
    output logic                  in_ale,
    output logic                  in_cmd,
    output logic                  busy,
    output cyc_kind_e             kind,
    output logic                  write,
    output logic                  dma,
    output logic                  narrow,
    output logic                  below_low,
    output logic                  upper_lane,
    output logic [ADDR_W-1:0]     sa,
    output logic [2*LANE_W-1:0]   sd_out,
    output logic                  done,
    output logic [2*LANE_W-1:0]   rdata
);
    localparam int DATA_W = 2 * LANE_W;

    seq_state_e          state;
    logic [ADDR_W-1:1]   addr_q;
    logic [1:0]          be_q;
    logic [DATA_W-1:0]   wdata_q;
    logic                wide_q;
    logic                part_q;
    logic                cur_high;
    logic                second_due;
    cyc_kind_e           req_kind;

    // Classify the incoming request; refresh wins over the I/O flag.
    always_comb begin
        if (req_refresh)  req_kind = KIND_REF;
        else if (req_io)  req_kind = KIND_IO;
        else              req_kind = KIND_MEM;
    end

    // Derive lane selection and the split decision from the latched cycle.
    always_comb begin
        cur_high   = part_q || (be_q == 2'b10);
        second_due = (kind != KIND_REF) && !wide_q && (be_q == 2'b11) && !part_q;
        req_ready  = (state == ST_IDLE);
        in_ale     = (state == ST_ALE);
        in_cmd     = (state == ST_CMD);
        busy       = (state != ST_IDLE);
        narrow     = !(wide_q || (kind == KIND_REF));
        below_low  = (addr_q[ADDR_W-1:LOW_BITS] == '0);
        upper_lane = in_cmd && (kind == KIND_MEM) && wide_q && be_q[1];
    end

    // Present the lane-adjusted address and the write lanes.
    always_comb begin
        sa = {addr_q, (kind != KIND_REF) && cur_high};
        if (wide_q) begin
            sd_out = wdata_q;
        end else begin
            sd_out = {{LANE_W{1'b0}},
                      cur_high ? wdata_q[DATA_W-1:LANE_W] : wdata_q[LANE_W-1:0]};
        end
    end

    // Phase sequencing, request capture and read-data assembly.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            addr_q  <= '0;
            be_q    <= '0;
            wdata_q <= '0;
            wide_q  <= 1'b0;
            part_q  <= 1'b0;
            kind    <= KIND_MEM;
            write   <= 1'b0;
            dma     <= 1'b0;
            done    <= 1'b0;
            rdata   <= '0;
        end else begin
            done <= 1'b0;
            unique case (state)
                ST_IDLE: begin
                    if (req_valid) begin
                        addr_q  <= req_addr[ADDR_W-1:1];
                        be_q    <= req_be;
                        wdata_q <= req_wdata;
                        kind    <= req_kind;
                        write   <= req_write && !req_refresh;
                        dma     <= req_dma && !req_refresh;
                        wide_q  <= 1'b0;
                        part_q  <= 1'b0;
                        rdata   <= '0;
                        state   <= ST_ALE;
                    end
                end
                ST_ALE: begin
                    if (!part_q) begin
                        wide_q <= (kind == KIND_MEM) && !mcs16_n;
                    end
                    state <= ST_CMD;
                end
                ST_CMD: begin
                    if (finish) begin
                        if (!write && (kind != KIND_REF)) begin
                            if (wide_q) begin
                                rdata <= {be_q[1] ? sd_in[DATA_W-1:LANE_W] : {LANE_W{1'b0}},
                                          be_q[0] ? sd_in[LANE_W-1:0]      : {LANE_W{1'b0}}};
                            end else if (cur_high) begin
                                rdata[DATA_W-1:LANE_W] <= sd_in[LANE_W-1:0];
                            end else begin
                                rdata[LANE_W-1:0] <= sd_in[LANE_W-1:0];
                            end
                        end
                        if (second_due) begin
                            part_q <= 1'b1;
                            state  <= ST_ALE;
                        end else begin
                            done  <= 1'b1;
                            state <= ST_IDLE;
                        end
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/isa_cmd_gen.sv
// Expansion-bus command generator, top level.
// Connects the cycle sequencer, the command width timer and the strobe
// decode. One cycle is in flight at a time.
// Assumes: bus inputs are synchronous to clk.
module isa_cmd_gen
    import isa_cmd_pkg::*;
#(
    parameter int ADDR_W   = 24,
    parameter int LOW_BITS = 20,
    parameter int LANE_W   = 8,
    parameter int W16      = 4,
    parameter int W8       = 6,
    parameter int WMIN     = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                req_valid,
    output logic                req_ready,
    input  logic [ADDR_W-1:0]   req_addr,
    input  logic                req_write,
    input  logic                req_io,
    input  logic                req_refresh,
    input  logic                req_dma,
    input  logic [1:0]          req_be,
    input  logic [2*LANE_W-1:0] req_wdata,
    output logic                done,
    output logic [2*LANE_W-1:0] rdata,
    output logic                ale,
    output logic [ADDR_W-1:0]   sa,
    output logic                bhe_n,
    output logic                memr_n,
    output logic                memw_n,
    output logic                ior_n,
    output logic                iow_n,
    output logic                smemr_n,
    output logic                smemw_n,
    output logic                aen,
    output logic [2*LANE_W-1:0] sd_out,
    input  logic [2*LANE_W-1:0] sd_in,
    input  logic                mcs16_n,
    input  logic                zws_n,
    input  logic                iochrdy
);
    cyc_kind_e kind;
    logic      in_cmd, busy, write, dma, narrow, below_low, upper_lane, finish;

    isa_cmd_seq #(
        .ADDR_W   (ADDR_W),
        .LOW_BITS (LOW_BITS),
        .LANE_W   (LANE_W)
    ) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_valid  (req_valid),
        .req_addr   (req_addr),
        .req_write  (req_write),
        .req_io     (req_io),
        .req_refresh(req_refresh),
        .req_dma    (req_dma),
        .req_be     (req_be),
        .req_wdata  (req_wdata),
        .mcs16_n    (mcs16_n),
        .sd_in      (sd_in),
        .finish     (finish),
        .req_ready  (req_ready),
        .in_ale     (ale),
        .in_cmd     (in_cmd),
        .busy       (busy),
        .kind       (kind),
        .write      (write),
        .dma        (dma),
        .narrow     (narrow),
        .below_low  (below_low),
        .upper_lane (upper_lane),
        .sa         (sa),
        .sd_out     (sd_out),
        .done       (done),
        .rdata      (rdata)
    );

    isa_cmd_width #(
        .W16  (W16),
        .W8   (W8),
        .WMIN (WMIN)
    ) u_width (
        .clk     (clk),
        .rst_n   (rst_n),
        .active  (in_cmd),
        .narrow  (narrow),
        .zws_n   (zws_n),
        .iochrdy (iochrdy),
        .finish  (finish)
    );

    isa_cmd_strobe u_strobe (
        .kind      (kind),
        .cmd_on    (in_cmd),
        .busy      (busy),
        .write     (write),
        .dma       (dma),
        .below_low (below_low),
        .memr_n    (memr_n),
        .memw_n    (memw_n),
        .ior_n     (ior_n),
        .iow_n     (iow_n),
        .smemr_n   (smemr_n),
        .smemw_n   (smemw_n),
        .aen       (aen)
    );

    // Byte-high enable is low-active on the bus.
    assign bhe_n = !upper_lane;

endmodule

// File: rtl/isa_cmd_gen_chk.sv
// Protocol checker for the command generator, bound to every instance.
// Assumes: iochrdy eventually returns high (not checked here).
module isa_cmd_gen_chk (
    input logic clk,
    input logic rst_n,
    input logic req_ready,
    input logic done,
    input logic ale,
    input logic bhe_n,
    input logic memr_n,
    input logic memw_n,
    input logic ior_n,
    input logic iow_n,
    input logic smemr_n,
    input logic smemw_n,
    input logic aen,
    input logic iochrdy
);
    logic cmd_on;
    assign cmd_on = !(memr_n && memw_n && ior_n && iow_n);

    // R2: the latch enable lasts one clock and never overlaps a command.
    assert_ale_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ale |=> !ale);
    assert_ale_no_cmd_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ale |-> !cmd_on);
    assert_cmd_after_ale_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cmd_on) |-> $past(ale));

    // R3: at most one command strobe at a time.
    assert_one_cmd_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({!memr_n, !memw_n, !ior_n, !iow_n}) <= 1);

    // R4: the low-megabyte strobes only accompany their command.
    assert_smemr_qual_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !smemr_n |-> !memr_n);
    assert_smemw_qual_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !smemw_n |-> !memw_n);

    // R5: the byte-high enable appears only in memory commands.
    assert_bhe_mem_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !bhe_n |-> (!memr_n || !memw_n));

    // R10: a command held by a not-ready channel stays active.
    assert_ready_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_on && !iochrdy) |=> cmd_on);

    // R11: the address enable is only seen while a cycle is running.
    assert_aen_busy_R11: assert property (@(posedge clk) disable iff (!rst_n)
        aen |-> !req_ready);

    // R12: completion is a single-clock pulse and coincides with idle.
    assert_done_pulse_R12: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    assert_done_idle_R12: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (req_ready && !cmd_on));

endmodule

bind isa_cmd_gen isa_cmd_gen_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_ready (req_ready),
    .done      (done),
    .ale       (ale),
    .bhe_n     (bhe_n),
    .memr_n    (memr_n),
    .memw_n    (memw_n),
    .ior_n     (ior_n),
    .iow_n     (iow_n),
    .smemr_n   (smemr_n),
    .smemw_n   (smemw_n),
    .aen       (aen),
    .iochrdy   (iochrdy)
);

// File: tb/isa_cmd_gen_test.sv
// Self-checking bench: sweeps cycle type, direction, byte enables, device
// width, address region and DMA flag, then timing variants.
module isa_cmd_gen_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [23:0] req_addr = '0;
    logic        req_write = 1'b0;
    logic        req_io = 1'b0;
    logic        req_refresh = 1'b0;
    logic        req_dma = 1'b0;
    logic [1:0]  req_be = 2'b00;
    logic [15:0] req_wdata = '0;
    logic        done;
    logic [15:0] rdata;
    logic        ale;
    logic [23:0] sa;
    logic        bhe_n, memr_n, memw_n, ior_n, iow_n, smemr_n, smemw_n, aen;
    logic [15:0] sd_out;
    logic [15:0] sd_in = '0;
    logic        mcs16_n = 1'b1;
    logic        zws_n = 1'b1;
    logic        iochrdy = 1'b1;

    int n_chk = 0;
    int n_bad = 0;
    int cycles = 0;

    isa_cmd_gen uut (.*);

    always #5 clk = !clk;

    // Watchdog: a hung run counts as a failure and still reports.
    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 150000) begin
            n_bad = n_bad + 1;
            $display("FAIL R12 watchdog expired: actual=%0d expected<150000", cycles);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string rq, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
        end
    endtask

    // kind: 0 memory, 1 I/O, 2 refresh
    task automatic run(input int kind, input bit wr, input bit [1:0] be, input bit mcs_low,
                       input bit above, input bit dma, input bit zws, input int nwait, input bit poke);
        logic [23:0] addr;
        logic [15:0] wd, pat, exp_rd;
        bit wide, is_ref, is_mem, split, exp_aen;
        int w, base, exp_len, exp_nx;
        logic [3:0] exp_cmd, cur, prev;
        int nx, cidx, ales, first;
        int lens[2];
        logic [23:0] sas[2];
        logic [15:0] sdo[2];
        bit fin;
        is_ref = (kind == 2);
        is_mem = (kind == 0);
        addr   = above ? 24'h3A5C3B : 24'h04C3A5;
        wd     = 16'hB4E1 ^ {8'h0, 2'b0, be, 1'b0, wr, 2'(kind)};
        pat    = 16'h6D92 ^ {be, 14'h0};
        wide   = is_mem && mcs_low;
        split  = !is_ref && !wide && (be == 2'b11);
        exp_nx = split ? 2 : 1;
        w      = (wide || is_ref) ? 4 : 6;
        base   = zws ? 2 : w;
        exp_len = (nwait + 1 > base) ? nwait + 1 : base;
        exp_aen = dma && !is_ref;
        if (is_ref)      exp_cmd = 4'b0001;
        else if (is_mem) exp_cmd = wr ? 4'b0010 : 4'b0001;
        else             exp_cmd = wr ? 4'b1000 : 4'b0100;
        if (wr || is_ref) exp_rd = 16'h0;
        else if (wide) exp_rd = {be[1] ? pat[15:8] : 8'h0, be[0] ? pat[7:0] : 8'h0};
        else exp_rd = {be[1] ? pat[7:0] : 8'h0, be[0] ? pat[7:0] : 8'h0};

        @(negedge clk);
        req_addr = addr; req_write = wr; req_io = (kind == 1); req_refresh = is_ref;
        req_dma = dma; req_be = be; req_wdata = wd; mcs16_n = !mcs_low; sd_in = pat;
        zws_n = 1'b1; iochrdy = 1'b1; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        prev = 4'b0; nx = 0; cidx = 0; ales = 0; first = 1; fin = 0;
        lens[0] = 0; lens[1] = 0; sas[0] = '0; sas[1] = '0; sdo[0] = '0; sdo[1] = '0;
        for (int k = 0; k < 80 && !fin; k++) begin
            req_valid = 1'b0;
            cur = {!iow_n, !ior_n, !memw_n, !memr_n};
            if (first == 1) chk(ale == 1'b1 && cur == 4'b0, "R2 ale after accept", {ale, cur}, 5'h10);
            first = 0;
            if (ale) begin
                ales++;
                chk(cur == 4'b0, "R2 no command with ale", cur, 0);
            end
            if (done) begin
                fin = 1;
                chk(req_ready == 1'b1 && cur == 4'b0, "R12 ready with done", req_ready, 1);
                chk(rdata == exp_rd, "R12 read data", rdata, exp_rd);
                chk(aen == 1'b0, "R11 aen after cycle", aen, 0);
            end else begin
                chk(aen == exp_aen, "R11 aen while busy", aen, exp_aen);
                chk(req_ready == 1'b0, "R12 not ready while busy", req_ready, 0);
            end
            if (cur != 4'b0) begin
                if (prev == 4'b0) begin
                    nx++;
                    if (nx <= 2) begin sas[nx-1] = sa; sdo[nx-1] = sd_out; end
                end
                cidx++;
                if (nx <= 2) lens[nx-1]++;
                chk(cur == exp_cmd, "R3 command strobe", cur, exp_cmd);
                chk(smemr_n == !(cur[0] && (!above || is_ref)), "R4 smemr", smemr_n, !(cur[0] && (!above || is_ref)));
                chk(smemw_n == !(cur[1] && !above), "R4 smemw", smemw_n, !(cur[1] && !above));
                chk(bhe_n == !(wide && be[1]), "R5 R7 bhe", bhe_n, !(wide && be[1]));
                zws_n = !zws;
                iochrdy = (cidx > nwait);
                if (poke && cidx == 2 && nx == 1) begin
                    req_valid = 1'b1; req_io = !req_io; req_write = !req_write;
                end
            end else begin
                cidx = 0;
                iochrdy = 1'b1;
                zws_n = 1'b1;
            end
            prev = cur;
            if (!fin) @(negedge clk);
        end
        chk(fin, "R12 cycle completed", fin, 1);
        chk(nx == exp_nx && ales == exp_nx, "R7 transfer count", nx, exp_nx);
        for (int t = 0; t < exp_nx; t++) begin
            logic [23:0] esa;
            logic [15:0] esd;
            bit a0;
            chk(lens[t] == exp_len, "R8 R9 R10 command length", lens[t], exp_len);
            a0 = is_ref ? 1'b0 : (split ? (t == 1) : (be == 2'b10));
            esa = {addr[23:1], a0};
            chk(sas[t] == esa, "R5 R6 R7 address lane", sas[t], esa);
            if (wr && !is_ref) begin
                esd = wide ? wd : {8'h0, a0 ? wd[15:8] : wd[7:0]};
                chk(sdo[t] == esd, "R5 R7 write lanes", sdo[t], esd);
            end
        end
        if (poke) begin
            for (int q = 0; q < 3; q++) begin
                @(negedge clk);
                chk(ale == 1'b0 && req_ready == 1'b1, "R12 busy request ignored", {ale, req_ready}, 1);
            end
        end
        @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(ale == 1'b0, "R1 ale", ale, 0);
        chk({memr_n, memw_n, ior_n, iow_n, smemr_n, smemw_n, bhe_n} == 7'h7F, "R1 strobes",
            {memr_n, memw_n, ior_n, iow_n, smemr_n, smemw_n, bhe_n}, 7'h7F);
        chk(aen == 1'b0 && done == 1'b0, "R1 aen done", {aen, done}, 0);
        chk(req_ready == 1'b1, "R1 ready", req_ready, 1);
        rst_n = 1'b1;
        @(negedge clk);
        chk(ale == 1'b0 && req_ready == 1'b1, "R1 idle after reset", {ale, req_ready}, 1);
        // Main sweep over the functional attributes.
        for (int kd = 0; kd < 3; kd++)
            for (int wr = 0; wr < 2; wr++)
                for (int b = 1; b < 4; b++)
                    for (int m = 0; m < 2; m++)
                        for (int ab = 0; ab < 2; ab++)
                            for (int d = 0; d < 2; d++)
                                run(kd, wr[0], b[1:0], m[0], ab[0], d[0], 1'b0, 0, 1'b0);
        // Timing sweep: zero-wait and channel-ready stretching.
        for (int kd = 0; kd < 3; kd++)
            for (int m = 0; m < 2; m++)
                for (int z = 0; z < 2; z++)
                    for (int nw = 0; nw < 9; nw += 3)
                        run(kd, 1'b0, 2'b11, m[0], 1'b0, 1'b0, z[0], nw, 1'b0);
        // Requests offered while busy are dropped.
        run(0, 1'b0, 2'b11, 1'b1, 1'b0, 1'b0, 1'b0, 0, 1'b1);
        run(1, 1'b1, 2'b01, 1'b0, 1'b0, 1'b1, 1'b0, 2, 1'b1);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule